// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Interrupts

This block is an asynchronous serial port that sits on a simple 32-bit register bus. Software writes characters into a single-entry holding register. A shifter sends each character as one start bit, eight data bits with the least significant bit first, and one stop bit. Received characters are sampled at the middle of each bit and presented in a receive register. The block flags overruns, framing errors and line breaks, and it detects a programmable end-of-packet character.

The status word and the control word use the same bit positions. Control bits 0 to 8, 10 and 12 are interrupt enables, so the interrupt output is the bitwise AND of the two words, reduced to one bit. Control bit 9 forces a break on the line, and control bit 11 drives the request-to-send output. The bit period is programmed as a count of system clocks.

Top module: `mmio_uart`

## Requirements
- R1: Registers are word aligned, selected by address bits 4:2 within a 32-byte window. The register at offset 0 reads the received character. Offset 4 takes transmit characters. Offset 8 is the status word and offset 12 is the control word. Offset 16 holds the clocks per bit, reset to DIV_RESET. Offset 20 holds the end-of-packet character. Offsets 16 and 20 read back what was written.
- R2: The status bits are as follows. Bit 0 is parity error, which always reads 0 because the frame carries no parity bit. Bit 1 is framing error and bit 2 is break. Bit 3 is receive overrun and bit 4 is transmit overrun. Bit 5 means the transmitter is empty and bit 6 means transmit is ready. Bit 7 means receive is ready and bit 8 is the exception bit. Bit 10 means CTS changed, bit 11 is the CTS level and bit 12 means end-of-packet was seen. After reset the status word reads 0x060.
- R3: A transmitted frame is low for one bit, then carries data bits 0 to 7, then is high for one bit. Each bit lasts exactly the programmed number of clocks. The idle line is high.
- R4: Transmit ready is high while the holding register is free. Transmitter empty is high only when both the holding register and the shifter are idle. A transmit write while transmit ready is low sets bit 4 and is discarded.
- R5: A received character sets bit 7. A read of offset 0 returns the character and clears bit 7.
- R6: A character that completes while bit 7 is still set raises bit 3 and replaces the stored character.
- R7: A stop bit sampled low sets bit 1. The character is still stored and bit 7 is still set.
- R8: A line held low for a whole frame, including the stop bit, sets bits 2 and 1, and the stored character reads 0.
- R9: Bit 8 reads as the OR of bits 0 to 4.
- R10: Any write to offset 8 clears bits 1, 2, 3, 4, 8, 10 and 12.
- R11: irq_o is high exactly when status AND control is nonzero over bits 0 to 8, 10 and 12. Control bits 9 and 11 never raise the interrupt.
- R12: While control bit 9 is set, txd_o is low. rts_o follows control bit 11.
- R13: Bit 11 shows the cts_i level after a two-stage synchronizer. Bit 10 is set on any change of that level.
- R14: A character received without a framing error that equals the end-of-packet register sets bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address within the register window |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read side effects) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send input |
| rts_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions take for granted that a bus cycle is either a read or a write and never both. They also assume the divisor is at least 2, and that the receive line is driven one frame at a time with bit timing that matches the programmed divisor. The bench drives one strobe per cycle and programs a divisor of 8. It shapes every receive frame bit by bit from that same divisor and waits a full frame plus margin before reading status. It sweeps all 256 character values in both directions. The receive sweep sits against an end-of-packet value that matches exactly one of them.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned REG_W  = 13;

  // word index = addr[4:2]
  localparam logic [2:0] W_RXD  = 3'd0;
  localparam logic [2:0] W_TXD  = 3'd1;
  localparam logic [2:0] W_STAT = 3'd2;
  localparam logic [2:0] W_CTRL = 3'd3;
  localparam logic [2:0] W_DIV  = 3'd4;
  localparam logic [2:0] W_EOP  = 3'd5;

  localparam int unsigned B_PE    = 0;
  localparam int unsigned B_FE    = 1;
  localparam int unsigned B_BRK   = 2;
  localparam int unsigned B_ROE   = 3;
  localparam int unsigned B_TOE   = 4;
  localparam int unsigned B_TMT   = 5;
  localparam int unsigned B_TRDY  = 6;
  localparam int unsigned B_RRDY  = 7;
  localparam int unsigned B_EXC   = 8;
  localparam int unsigned B_TXBRK = 9;
  localparam int unsigned B_DCTS  = 10;
  localparam int unsigned B_CTS   = 11;
  localparam int unsigned B_RTS   = 11;
  localparam int unsigned B_EOP   = 12;

  // interrupt-capable positions: 0..8, 10, 12
  localparam logic [REG_W-1:0] IRQ_MASK = 13'h15FF;
endpackage

// File: rtl/mmio_uart_sync.sv
module mmio_uart_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              hold_full_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned FRAME_BITS = CHAR_W + 2;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [CHAR_W-1:0]     hold_q;
  logic                  hold_full_q;
  logic                  busy_q;
  logic [FRAME_BITS-1:0] shift_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [BIT_W-1:0]      bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      shift_q     <= '1;
      cnt_q       <= '0;
      bit_q       <= '0;
    end else begin
      if (!busy_q && hold_full_q) begin
        shift_q     <= {1'b1, hold_q, 1'b0};
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        bit_q       <= '0;
        hold_full_q <= 1'b0;
      end else begin
        if (wr_i && !hold_full_q) begin
          hold_q      <= data_i;
          hold_full_q <= 1'b1;
        end
        if (busy_q) begin
          if (cnt_q == div_i - 1'b1) begin
            cnt_q   <= '0;
            shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
            if (bit_q == LAST_BIT) busy_q <= 1'b0;
            else                   bit_q  <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign hold_full_o = hold_full_q;
  assign busy_o      = busy_q;
  assign txd_o       = busy_q ? shift_q[0] : 1'b1;
endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rxd_i,     // already synchronized
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int unsigned BIT_W = $clog2(CHAR_W);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(CHAR_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_WAIT_HIGH} rx_state_e;

  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CHAR_W-1:0] shift_q;
  logic              done_q, ferr_q, brk_q;
  logic [DIV_W-1:0]  half_w;

  assign half_w = div_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (!rxd_i) begin
          state_q <= S_START;
          cnt_q   <= '0;
        end
        S_START: begin
          if (cnt_q == half_w - 1'b1) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rxd_i ? S_IDLE : S_DATA;  // glitch rejected
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == div_i - 1'b1) begin
            cnt_q   <= '0;
            shift_q <= {rxd_i, shift_q[CHAR_W-1:1]};
            if (bit_q == LAST_DATA) state_q <= S_STOP;
            else                    bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == div_i - 1'b1) begin
            cnt_q   <= '0;
            done_q  <= 1'b1;
            ferr_q  <= !rxd_i;
            brk_q   <= !rxd_i && (shift_q == '0);
            state_q <= rxd_i ? S_IDLE : S_WAIT_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WAIT_HIGH: if (rxd_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = shift_q;
  assign ferr_o = ferr_q;
  assign brk_o  = brk_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              cts_i,
  output logic              rts_o,
  output logic              irq_o
);
  logic [2:0] sel_w;
  assign sel_w = addr_i[4:2];

  logic wr_txd, wr_stat, wr_ctrl, wr_div, wr_eop, rd_rxd;
  assign wr_txd  = wr_en_i && (sel_w == W_TXD);
  assign wr_stat = wr_en_i && (sel_w == W_STAT);
  assign wr_ctrl = wr_en_i && (sel_w == W_CTRL);
  assign wr_div  = wr_en_i && (sel_w == W_DIV);
  assign wr_eop  = wr_en_i && (sel_w == W_EOP);
  assign rd_rxd  = rd_en_i && (sel_w == W_RXD);

  logic [REG_W-1:0]  ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] eop_q, rx_data_q;
  logic fe_q, brk_q, roe_q, toe_q, rrdy_q, dcts_q, eop_seen_q, cts_prev_q;

  logic rxd_s, cts_s;
  mmio_uart_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rxd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s));
  mmio_uart_sync #(.STAGES(2), .RST_VAL(1'b0)) u_cts_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_i), .q_o(cts_s));

  logic hold_full, tx_busy, tx_line;
  mmio_uart_tx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q),
    .wr_i(wr_txd), .data_i(wdata_i[CHAR_W-1:0]),
    .hold_full_o(hold_full), .busy_o(tx_busy), .txd_o(tx_line));

  logic              rx_done, rx_ferr, rx_brk;
  logic [CHAR_W-1:0] rx_char;
  mmio_uart_rx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q), .rxd_i(rxd_s),
    .done_o(rx_done), .data_o(rx_char), .ferr_o(rx_ferr), .brk_o(rx_brk));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      div_q      <= DIV_W'(DIV_RESET);
      eop_q      <= '0;
      rx_data_q  <= '0;
      fe_q       <= 1'b0;
      brk_q      <= 1'b0;
      roe_q      <= 1'b0;
      toe_q      <= 1'b0;
      rrdy_q     <= 1'b0;
      dcts_q     <= 1'b0;
      eop_seen_q <= 1'b0;
      cts_prev_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[REG_W-1:0];
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
      if (wr_eop)  eop_q  <= wdata_i[CHAR_W-1:0];
      if (rx_done) rx_data_q <= rx_brk ? '0 : rx_char;
      cts_prev_q <= cts_s;

      if (rx_done)     rrdy_q <= 1'b1;
      else if (rd_rxd) rrdy_q <= 1'b0;

      // sticky flags: a set in the same cycle as a clear wins
      fe_q       <= (fe_q  && !wr_stat) || (rx_done && rx_ferr);
      brk_q      <= (brk_q && !wr_stat) || (rx_done && rx_brk);
      roe_q      <= (roe_q && !wr_stat) || (rx_done && rrdy_q && !rd_rxd);
      toe_q      <= (toe_q && !wr_stat) || (wr_txd && hold_full);
      dcts_q     <= (dcts_q && !wr_stat) || (cts_s != cts_prev_q);
      eop_seen_q <= (eop_seen_q && !wr_stat) ||
                    (rx_done && !rx_ferr && (rx_char == eop_q));
    end
  end

  logic [REG_W-1:0] status_w;
  logic             exc_w;
  assign exc_w = fe_q | brk_q | roe_q | toe_q;  // parity flag is constant 0
  assign status_w = {eop_seen_q, cts_s, dcts_q, 1'b0, exc_w, rrdy_q,
                     !hold_full, !hold_full && !tx_busy,
                     toe_q, roe_q, brk_q, fe_q, 1'b0};

  always_comb begin
    rdata_o = '0;
    unique case (sel_w)
      W_RXD:   rdata_o[CHAR_W-1:0] = rx_data_q;
      W_STAT:  rdata_o[REG_W-1:0]  = status_w;
      W_CTRL:  rdata_o[REG_W-1:0]  = ctrl_q;
      W_DIV:   rdata_o[DIV_W-1:0]  = div_q;
      W_EOP:   rdata_o[CHAR_W-1:0] = eop_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(status_w & ctrl_q & IRQ_MASK);
  assign txd_o = ctrl_q[B_TXBRK] ? 1'b0 : tx_line;
  assign rts_o = ctrl_q[B_RTS];

  logic unused_ok;
  assign unused_ok = ^{addr_i[1:0], wdata_i[DATA_W-1:REG_W]};
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk
  import mmio_uart_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              txd_o,
  input logic              rts_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  status_i,
  input logic [REG_W-1:0]  ctrl_i,
  input logic              rx_done_i
);
  logic [2:0] sel;
  assign sel = addr_i[4:2];

  p_toe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == W_TXD && !status_i[B_TRDY]) |=> (status_i[B_TOE] && status_i[B_EXC]));

  p_empty_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[B_TMT] |-> status_i[B_TRDY]);

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[B_TMT] && !ctrl_i[B_TXBRK]) |-> txd_o);

  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == W_RXD && !rx_done_i) |=> !status_i[B_RRDY]);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == W_STAT && !rx_done_i) |=>
      !(status_i[B_FE] || status_i[B_BRK] || status_i[B_ROE] || status_i[B_TOE] || status_i[B_EXC]));

  p_break_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == W_CTRL && wdata_i[B_TXBRK]) |=> !txd_o);

  p_rts_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == W_CTRL) |=> (rts_o == $past(wdata_i[B_RTS])));

  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_i & IRQ_MASK) == '0) |-> !irq_o);

  p_parity_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i[B_PE]);
endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .txd_o(txd_o), .rts_o(rts_o),
  .irq_o(irq_o), .status_i(status_w), .ctrl_i(ctrl_q), .rx_done_i(rx_done));

// File: tb/mmio_uart_tb.sv
module mmio_uart_tb;
  localparam int DIV = 8;
  localparam logic [4:0] A_RXD = 5'd0, A_TXD = 5'd4, A_STAT = 5'd8,
                         A_CTRL = 5'd12, A_DIV = 5'd16, A_EOP = 5'd20;
  localparam logic [7:0] EOP_CH = 8'h3C;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        rxd_i = 1'b1, txd_o, cts_i = 1'b0, rts_o, irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mmio_uart #(.DIV_W(16), .DIV_RESET(16)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rxd_i(rxd_i),
    .txd_o(txd_o), .cts_i(cts_i), .rts_o(rts_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic tx_capture(output logic [7:0] b, output bit ok);
    int waited = 0;
    ok = 1'b1;
    b = '0;
    while (txd_o !== 1'b0 && waited < 4 * DIV) begin
      tick(1); waited++;
    end
    if (txd_o !== 1'b0) ok = 1'b0;
    tick(DIV / 2);
    if (txd_o !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(DIV); b[i] = txd_o;
    end
    tick(DIV);
    if (txd_o !== 1'b1) ok = 1'b0;
    tick(DIV);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop_v);
    rxd_i = 1'b0; tick(DIV);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i]; tick(DIV);
    end
    rxd_i = stop_v; tick(DIV);
    rxd_i = 1'b1; tick(4);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  cap;
    bit          ok;
    int          w;
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    bus_rd(A_STAT, d); chk("R2 reset status", d, 32'h060);
    chk("R3 reset idle line", {31'd0, txd_o}, 32'd1);
    chk("R11 reset irq", {31'd0, irq_o}, 32'd0);
    chk("R12 reset rts", {31'd0, rts_o}, 32'd0);
    bus_rd(A_DIV, d); chk("R1 divisor reset", d, 32'd16);

    bus_wr(A_DIV, DIV);
    bus_rd(A_DIV, d); chk("R1 divisor readback", d, DIV);
    bus_wr(A_EOP, {24'd0, EOP_CH});
    bus_rd(A_EOP, d); chk("R1 eop readback", d, {24'd0, EOP_CH});

    // R3: transmit sweep over every character
    for (int v = 0; v < 256; v++) begin
      bus_wr(A_TXD, v);
      tx_capture(cap, ok);
      chk("R3 tx frame shape", {31'd0, ok}, 32'd1);
      chk("R3 tx data", {24'd0, cap}, v);
    end
    bus_rd(A_STAT, d); chk("R4 idle after tx", d, 32'h060);

    // R4: holding register full -> overrun and discard
    bus_wr(A_TXD, 32'hA5);
    tick(1);
    bus_wr(A_TXD, 32'h5A);
    bus_rd(A_STAT, d); chk("R4 hold full status", d & 32'h070, 32'h000);
    bus_wr(A_TXD, 32'hFF);
    bus_rd(A_STAT, d); chk("R4 R9 overrun flagged", d, 32'h110);
    w = 0;
    d = 0;
    while (w < 30 * DIV && d[5] !== 1'b1) begin bus_rd(A_STAT, d); w++; end
    chk("R4 drains to empty", d, 32'h170);
    bus_wr(A_STAT, 0);
    bus_rd(A_STAT, d); chk("R10 toe cleared", d, 32'h060);

    // R5 R14: receive sweep
    for (int v = 0; v < 256; v++) begin
      rx_send(v[7:0], 1'b1);
      bus_rd(A_STAT, d);
      chk("R5 R14 rx status", d, (v == EOP_CH) ? 32'h10E0 : 32'h0E0);
      bus_rd(A_RXD, d); chk("R5 rx data", d, v);
      bus_wr(A_STAT, 0);
      bus_rd(A_STAT, d); chk("R5 read clears ready", d, 32'h060);
    end

    // R6: overrun replaces data
    rx_send(8'h11, 1'b1);
    rx_send(8'h22, 1'b1);
    bus_rd(A_STAT, d); chk("R6 R9 rx overrun", d, 32'h1E8);
    bus_rd(A_RXD, d);  chk("R6 newest data kept", d, 32'h22);
    bus_wr(A_STAT, 0);
    bus_rd(A_STAT, d); chk("R10 roe cleared", d, 32'h060);

    // R7: framing error, R14 not raised on bad frame
    rx_send(EOP_CH, 1'b0);
    bus_rd(A_STAT, d); chk("R7 R14 framing", d, 32'h1E2);
    bus_rd(A_RXD, d);  chk("R7 data kept", d, {24'd0, EOP_CH});
    bus_wr(A_STAT, 0);

    // R8: break
    rx_send(8'h00, 1'b0);
    bus_rd(A_STAT, d); chk("R8 break", d, 32'h1E6);
    bus_rd(A_RXD, d);  chk("R8 break data", d, 32'h0);
    bus_wr(A_STAT, 0);
    bus_rd(A_STAT, d); chk("R10 brk fe cleared", d, 32'h060);

    // R11: interrupt masking
    bus_wr(A_CTRL, 32'h040);
    chk("R11 irq on tx ready", {31'd0, irq_o}, 32'd1);
    bus_wr(A_CTRL, 32'h080);
    chk("R11 irq rx enable idle", {31'd0, irq_o}, 32'd0);
    rx_send(8'h42, 1'b1);
    chk("R11 irq on rx ready", {31'd0, irq_o}, 32'd1);
    bus_rd(A_RXD, d);
    chk("R11 irq drops on read", {31'd0, irq_o}, 32'd0);

    // R13: CTS tracking; R11: bit 11 is not an enable
    bus_wr(A_CTRL, 32'h0);
    cts_i = 1'b1; tick(4);
    bus_rd(A_STAT, d); chk("R13 cts level and change", d, 32'hC60);
    bus_wr(A_CTRL, 32'h800);
    chk("R12 rts follows", {31'd0, rts_o}, 32'd1);
    chk("R11 bit11 no irq", {31'd0, irq_o}, 32'd0);
    bus_wr(A_CTRL, 32'h400);
    chk("R11 R13 irq on cts change", {31'd0, irq_o}, 32'd1);
    bus_wr(A_STAT, 0);
    chk("R10 dcts cleared irq", {31'd0, irq_o}, 32'd0);
    bus_rd(A_CTRL, d); chk("R1 ctrl readback", d, 32'h400);

    // R12: forced break on the line
    bus_wr(A_CTRL, 32'h200);
    chk("R12 break holds low", {31'd0, txd_o}, 32'd0);
    chk("R11 bit9 no irq", {31'd0, irq_o}, 32'd0);
    bus_wr(A_CTRL, 32'h0);
    chk("R12 line released", {31'd0, txd_o}, 32'd1);
    chk("R12 rts low", {31'd0, rts_o}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule